// File: doc/BRIEF.md
# Pulse-Width Remote Frame Decoder

This block sits behind a sub-GHz on-off-keyed receiver and turns the demodulated data line into decoded remote-control frames. It times every high and low run of the line in units of a one-microsecond tick strobe. Each run is sorted into short, long or invalid. A high run and the low run that follows it form one bit symbol.

Each frame opens with a preamble that is checked on the fly. The bits after it are cut into nine-bit groups, and each group must pass a parity check. A silent low gap closes the frame. The decoder then checks the frame length and an additive checksum. If every check holds, it presents a 16-bit house code, an 8-bit address and an 8-bit or 16-bit command, and raises a one-cycle strobe.

Any fault drops the frame without a trace. The decoder then waits for the line to go quiet and hunts for the next frame.

Top module: `pwm_frame_decoder`

## Requirements
- R1: A run lasting SHORT_MIN_US to SHORT_MAX_US ticks (inclusive) is short. A run lasting more than SHORT_MAX_US and at most LONG_MAX_US ticks is long. Any other length inside a frame makes the decoder drop the frame.
- R2: A frame starts at a rising edge. Each high run followed by a low run is one symbol. Short+short is bit 0 and long+long is bit 1. A mixed pair drops the frame.
- R3: The first SYNC_ZEROS+1 bits (12 zeros, then a 1) must match exactly, or the frame is dropped.
- R4: The following bits form groups of nine. Each group holds eight data bits, MSB first, then one parity bit. The count of ones in the group must be even, or the frame is dropped.
- R5: Let S be 6 plus the sum, modulo 256, of all data bytes except the last. The frame is accepted only when the last byte minus S (modulo 256) is 0, 1 or 2.
- R6: A low run reaching GAP_US ticks ends the frame. That closing low is counted as the last pulse and is not classified. The frame is accepted only with 117 measured pulses (5 bytes) or 135 measured pulses (6 bytes); together with the closing low these give 118 and 136. The high half of the final trailer symbol must be a valid pulse, and its value is ignored.
- R7: On acceptance the outputs are set as follows. house_code = {byte0, byte1} and address = byte2. A 5-byte frame gives command = {8'h00, byte3} with command_wide = 0. A 6-byte frame gives command = {byte3, byte4} with command_wide = 1.
- R8: frame_valid is high for exactly one cycle per accepted frame. The output fields hold their values while frames are dropped. A dropped frame does not stop the next good frame from being decoded.
- R9: After reset, frame_valid is 0 and all output fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe each microsecond (time unit for run lengths) |
| rx_data | input | 1 | Demodulated on-off-keyed line, asynchronous |
| frame_valid | output | 1 | One-cycle strobe for an accepted frame |
| house_code | output | 16 | Decoded house code |
| address | output | 8 | Decoded address |
| command | output | 16 | Decoded command (upper byte zero for short commands) |
| command_wide | output | 1 | 1 when the command came from a 6-byte frame |

## Verification
The hardest cases to reach are run lengths sitting exactly on the window edges. They only show up when a precise duration lands on a chosen pulse deep inside an otherwise valid frame. The bench builds every frame as a list of per-pulse durations, with parity and checksum computed by its own functions. It then overwrites single entries with edge values (one below, at, and one above each limit), flips single bits, or trims and extends the pulse list. Random frames use random run lengths drawn inside the windows and random checksum offsets, so that both accepted and rejected frames appear.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    PK_BAD   = 2'd0,
    PK_SHORT = 2'd1,
    PK_LONG  = 2'd2
  } pkind_e;
endpackage

// File: rtl/pfd_run_timer.sv
// Synchronises the line, times each run in ticks, classifies it at the
// closing edge and flags a low run that reaches the gap limit.
module pfd_run_timer
  import pfd_pkg::*;
#(
  parameter int SHORT_MIN_US = 300,
  parameter int SHORT_MAX_US = 500,
  parameter int LONG_MAX_US  = 750,
  parameter int GAP_US       = 2000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick_i,
  input  logic   line_i,
  output logic   run_end_o,
  output logic   run_high_o,
  output pkind_e run_kind_o,
  output logic   gap_o
);
  localparam int CW = $clog2(GAP_US + 1);
  localparam logic [CW-1:0] SMIN   = CW'(SHORT_MIN_US);
  localparam logic [CW-1:0] SMAX   = CW'(SHORT_MAX_US);
  localparam logic [CW-1:0] LMAX   = CW'(LONG_MAX_US);
  localparam logic [CW-1:0] GAPC   = CW'(GAP_US);
  localparam logic [CW-1:0] GAP_M1 = CW'(GAP_US - 1);

  logic [2:0]    sync_q;
  logic [CW-1:0] len_q, len_d;
  logic          edge_w;

  assign edge_w = sync_q[1] ^ sync_q[2];

  always_comb begin
    len_d = len_q;
    if (edge_w)                      len_d = tick_i ? CW'(1) : '0;
    else if (tick_i && len_q != GAPC) len_d = len_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      len_q  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], line_i};
      len_q  <= len_d;
    end
  end

  always_comb begin
    if (len_q >= SMIN && len_q <= SMAX)     run_kind_o = PK_SHORT;
    else if (len_q > SMAX && len_q <= LMAX) run_kind_o = PK_LONG;
    else                                    run_kind_o = PK_BAD;
  end

  assign run_end_o  = edge_w;
  assign run_high_o = sync_q[2];
  assign gap_o      = !edge_w && tick_i && !sync_q[1] && (len_q == GAP_M1);

  // R6: the gap flag fires once per quiet stretch
  a_r6_gap_once: assert property (@(posedge clk) disable iff (!rst_n)
    gap_o |=> !gap_o);
  // R6: a gap is only reported while the line sits low
  a_r6_gap_low: assert property (@(posedge clk) disable iff (!rst_n)
    gap_o |=> !run_high_o || run_end_o);
endmodule

// File: rtl/pfd_frame_asm.sv
// Pairs runs into bits, checks preamble, group parity, length and checksum,
// and loads the output fields on acceptance.
module pfd_frame_asm
  import pfd_pkg::*;
#(
  parameter int SYNC_ZEROS = 12,
  parameter int BYTES_MIN  = 5,
  parameter int BYTES_MAX  = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_end_i,
  input  logic        run_high_i,
  input  pkind_e      run_kind_i,
  input  logic        gap_i,
  output logic        valid_o,
  output logic [15:0] house_o,
  output logic [7:0]  addr_o,
  output logic [15:0] cmd_o,
  output logic        wide_o
);
  localparam int GRP     = 9;
  localparam int SBITS   = SYNC_ZEROS + 1;
  localparam int P_SHORT = 2 * (SBITS + GRP * BYTES_MIN + 1) - 1;
  localparam int P_LONG  = 2 * (SBITS + GRP * BYTES_MAX + 1) - 1;
  localparam int PW      = $clog2(P_LONG + 2);
  localparam int BW      = $clog2(BYTES_MAX + 1);
  localparam logic [PW-1:0] PS      = PW'(P_SHORT);
  localparam logic [PW-1:0] PL      = PW'(P_LONG);
  localparam logic [PW-1:0] SB      = PW'(SBITS);
  localparam logic [PW-1:0] SB_LAST = PW'(SBITS - 1);
  localparam logic [BW-1:0] NB      = BW'(BYTES_MAX);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DROP} st_e;

  st_e           st_q, st_d;
  logic [PW-1:0] pcnt_q, pcnt_d, bitn_q, bitn_d;
  pkind_e        first_q, first_d;
  logic [3:0]    gpos_q, gpos_d;
  logic [7:0]    shf_q, shf_d, sum_q, sum_d, last_q, last_d, diff;
  logic          par_q, par_d, bit_ev, bit_v, acc, len_ok;
  logic [BW-1:0] nby_q, nby_d;
  logic [7:0]    byt_q [BYTES_MAX];
  logic [7:0]    byt_d [BYTES_MAX];

  always_comb begin
    st_d = st_q;   pcnt_d = pcnt_q; first_d = first_q; bitn_d = bitn_q;
    gpos_d = gpos_q; shf_d = shf_q; par_d = par_q; nby_d = nby_q;
    sum_d = sum_q; last_d = last_q; byt_d = byt_q;
    bit_ev = 1'b0; bit_v = 1'b0; acc = 1'b0;
    diff   = last_q - (sum_q - last_q + 8'd6);
    len_ok = (pcnt_q == PS) || (pcnt_q == PL);
    if (gap_i) begin
      st_d = ST_IDLE;
      acc  = (st_q == ST_RUN) && len_ok && (diff <= 8'd2);
    end else if (run_end_i) begin
      case (st_q)
        ST_IDLE: if (run_high_i) begin
          pcnt_d = PW'(1); first_d = run_kind_i; bitn_d = '0; gpos_d = '0;
          shf_d = '0; par_d = 1'b0; nby_d = '0; sum_d = '0; last_d = '0;
          st_d = (run_kind_i == PK_BAD) ? ST_DROP : ST_RUN;
        end
        ST_RUN: if (run_kind_i == PK_BAD || pcnt_q == PL) st_d = ST_DROP;
        else begin
          pcnt_d = pcnt_q + 1'b1;
          if (run_high_i)                first_d = run_kind_i;
          else if (run_kind_i != first_q) st_d = ST_DROP;
          else begin
            bit_ev = 1'b1;
            bit_v  = (run_kind_i == PK_LONG);
          end
        end
        default: ;
      endcase
    end
    if (bit_ev) begin
      bitn_d = bitn_q + 1'b1;
      if (bitn_q < SB) begin
        if (bit_v != (bitn_q == SB_LAST)) st_d = ST_DROP;
      end else if (gpos_q == 4'd8) begin
        if (par_q ^ bit_v) st_d = ST_DROP;
        else if (nby_q < NB) begin
          byt_d[nby_q] = shf_q;
          sum_d  = sum_q + shf_q;
          last_d = shf_q;
          nby_d  = nby_q + 1'b1;
        end
        gpos_d = '0;
        par_d  = 1'b0;
      end else begin
        shf_d  = {shf_q[6:0], bit_v};
        par_d  = par_q ^ bit_v;
        gpos_d = gpos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; pcnt_q <= '0; first_q <= PK_BAD; bitn_q <= '0;
      gpos_q <= '0; shf_q <= '0; par_q <= 1'b0; nby_q <= '0;
      sum_q <= '0; last_q <= '0;
      for (int i = 0; i < BYTES_MAX; i++) byt_q[i] <= '0;
    end else begin
      st_q <= st_d; pcnt_q <= pcnt_d; first_q <= first_d; bitn_q <= bitn_d;
      gpos_q <= gpos_d; shf_q <= shf_d; par_q <= par_d; nby_q <= nby_d;
      sum_q <= sum_d; last_q <= last_d;
      for (int i = 0; i < BYTES_MAX; i++) byt_q[i] <= byt_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0; house_o <= '0; addr_o <= '0; cmd_o <= '0; wide_o <= 1'b0;
    end else begin
      valid_o <= acc;
      if (acc) begin
        house_o <= {byt_q[0], byt_q[1]};
        addr_o  <= byt_q[2];
        wide_o  <= (pcnt_q == PL);
        cmd_o   <= (pcnt_q == PL) ? {byt_q[3], byt_q[4]} : {8'h00, byt_q[3]};
      end
    end
  end

  // R8: one-cycle strobe
  a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  // R6: acceptance only follows a gap
  a_r6_valid_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(gap_i));
  // R8: fields hold between accepted frames
  a_r8_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(house_o) && $stable(addr_o) && $stable(cmd_o));
  // R2: a low run never opens a frame
  a_r2_low_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && run_end_i && !run_high_i && !gap_i) |=> st_q == ST_IDLE);
endmodule

// File: rtl/pwm_frame_decoder.sv
module pwm_frame_decoder
  import pfd_pkg::*;
#(
  parameter int SHORT_MIN_US = 300,
  parameter int SHORT_MAX_US = 500,
  parameter int LONG_MAX_US  = 750,
  parameter int GAP_US       = 2000,
  parameter int SYNC_ZEROS   = 12,
  parameter int BYTES_MIN    = 5,
  parameter int BYTES_MAX    = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_us,
  input  logic        rx_data,
  output logic        frame_valid,
  output logic [15:0] house_code,
  output logic [7:0]  address,
  output logic [15:0] command,
  output logic        command_wide
);
  logic   run_end, run_high, gap;
  pkind_e run_kind;

  pfd_run_timer #(
    .SHORT_MIN_US(SHORT_MIN_US), .SHORT_MAX_US(SHORT_MAX_US),
    .LONG_MAX_US(LONG_MAX_US),   .GAP_US(GAP_US)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_us), .line_i(rx_data),
    .run_end_o(run_end), .run_high_o(run_high), .run_kind_o(run_kind), .gap_o(gap)
  );

  pfd_frame_asm #(
    .SYNC_ZEROS(SYNC_ZEROS), .BYTES_MIN(BYTES_MIN), .BYTES_MAX(BYTES_MAX)
  ) u_asm (
    .clk(clk), .rst_n(rst_n), .run_end_i(run_end), .run_high_i(run_high),
    .run_kind_i(run_kind), .gap_i(gap), .valid_o(frame_valid),
    .house_o(house_code), .addr_o(address), .cmd_o(command), .wide_o(command_wide)
  );
endmodule

// File: tb/sim_pwm_frame_decoder.sv
`timescale 1ns/1ps
module sim_pwm_frame_decoder;
  localparam int SMIN = 12, SMAX = 20, LMAX = 30, GAP = 80;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, rx = 1'b0;
  logic frame_valid, command_wide;
  logic [15:0] house_code, command;
  logic [7:0]  address;

  always #2.5 clk = ~clk;

  pwm_frame_decoder #(.SHORT_MIN_US(SMIN), .SHORT_MAX_US(SMAX),
    .LONG_MAX_US(LMAX), .GAP_US(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_us(tick), .rx_data(rx),
    .frame_valid(frame_valid), .house_code(house_code), .address(address),
    .command(command), .command_wide(command_wide));

  int total = 0, bad = 0, vtot = 0;
  bit finished = 1'b0;
  logic fb [0:71];
  int nb, np;
  int pd [0:143];
  logic [15:0] cap_hc, cap_cmd, held_hc;
  logic [7:0]  cap_adr;
  logic        cap_w;

  always @(negedge clk) if (frame_valid) begin
    vtot++; cap_hc = house_code; cap_adr = address; cap_cmd = command; cap_w = command_wide;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic b); fb[nb] = b; nb++; endtask

  task automatic build(input logic [15:0] hc, input logic [7:0] adr,
                       input logic [15:0] cmd, input bit wide, input int csoff);
    logic [7:0] by [0:5];
    logic [7:0] s;
    int n;
    nb = 0;
    for (int i = 0; i < 12; i++) push(1'b0);
    push(1'b1);
    by[0] = hc[15:8]; by[1] = hc[7:0]; by[2] = adr;
    if (wide) begin by[3] = cmd[15:8]; by[4] = cmd[7:0]; n = 6; end
    else begin by[3] = cmd[7:0]; n = 5; end
    s = 8'd6;
    for (int i = 0; i < n - 1; i++) s = s + by[i];
    by[n-1] = s + 8'(csoff);
    for (int i = 0; i < n; i++) begin
      for (int k = 7; k >= 0; k--) push(by[i][k]);
      push(^by[i]);
    end
    push(1'b0);
  endtask

  task automatic to_pulses(input bit rnd);
    np = 0;
    for (int i = 0; i < nb; i++) begin
      for (int h = 0; h < 2; h++) begin
        if (h == 0 || i < nb - 1) begin
          if (fb[i]) pd[np] = rnd ? 21 + int'($urandom % 10) : 25;
          else       pd[np] = rnd ? 12 + int'($urandom % 9)  : 16;
          np++;
        end
      end
    end
  endtask

  task automatic send();
    for (int k = 0; k < np; k++) begin
      rx = (k % 2 == 0);
      repeat (pd[k]) @(negedge clk);
    end
    rx = 1'b0;
    repeat (GAP + 20) @(negedge clk);
  endtask

  task automatic run(input string req, input bit ok, input logic [15:0] hc,
                     input logic [7:0] adr, input logic [15:0] cmd, input bit wide);
    int v0;
    v0 = vtot;
    send();
    chk({req, " strobe count"}, vtot - v0, ok ? 1 : 0);
    if (ok) begin
      chk({req, " R7 house"}, cap_hc, hc);
      chk({req, " R7 addr"}, cap_adr, adr);
      chk({req, " R7 cmd"}, cap_cmd, wide ? cmd : {8'h00, cmd[7:0]});
      chk({req, " R7 wide"}, cap_w, wide);
      held_hc = hc;
    end else chk({req, " R8 held"}, house_code, held_hc);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int r;
    logic [15:0] h, c;
    logic [7:0] a;
    bit w;
    int co;
    r = $urandom(32'h5eed);
    held_hc = 16'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 valid", frame_valid, 0);
    chk("R9 house", house_code, 0);
    chk("R9 addr", address, 0);
    chk("R9 cmd", command, 0);
    chk("R9 wide", command_wide, 0);
    repeat (GAP + 10) @(negedge clk);

    build(16'hA53C, 8'h12, 16'h0011, 0, 0); to_pulses(0);
    run("R7 narrow", 1, 16'hA53C, 8'h12, 16'h0011, 0);
    build(16'h1234, 8'hFE, 16'hBEEF, 1, 0); to_pulses(0);
    run("R7 wide", 1, 16'h1234, 8'hFE, 16'hBEEF, 1);
    build(16'h0F0F, 8'h40, 16'h0022, 0, 1); to_pulses(1);
    run("R5 offset1", 1, 16'h0F0F, 8'h40, 16'h0022, 0);
    build(16'h7001, 8'h03, 16'h0099, 0, 2); to_pulses(1);
    run("R5 offset2", 1, 16'h7001, 8'h03, 16'h0099, 0);
    build(16'h7002, 8'h03, 16'h0099, 0, 3); to_pulses(0);
    run("R5 offset3", 0, 0, 0, 0, 0);
    build(16'h7003, 8'h03, 16'h0099, 1, 255); to_pulses(0);
    run("R5 offset minus1", 0, 0, 0, 0, 0);

    // R1 window edges accepted
    build(16'h2222, 8'h33, 16'h0044, 0, 0); to_pulses(0);
    pd[0] = SMIN; pd[1] = SMAX; pd[24] = SMAX + 1; pd[25] = LMAX;
    run("R1 edges ok", 1, 16'h2222, 8'h33, 16'h0044, 0);
    build(16'h2223, 8'h33, 16'h0044, 0, 0); to_pulses(0); pd[2] = SMIN - 1;
    run("R1 below short", 0, 0, 0, 0, 0);
    build(16'h2224, 8'h33, 16'h0044, 0, 0); to_pulses(0); pd[25] = LMAX + 1;
    run("R1 above long", 0, 0, 0, 0, 0);
    // R2 mixed symbol
    build(16'h2225, 8'h33, 16'h0044, 0, 0); to_pulses(0); pd[3] = 25;
    run("R2 mixed pair", 0, 0, 0, 0, 0);
    // R3 preamble broken
    build(16'h2226, 8'h33, 16'h0044, 0, 0); fb[5] = 1'b1; to_pulses(0);
    run("R3 bad preamble", 0, 0, 0, 0, 0);
    // R4 parity flipped in third group
    build(16'h2227, 8'h33, 16'h0044, 0, 0); fb[13 + 2*9 + 8] = ~fb[13 + 2*9 + 8]; to_pulses(0);
    run("R4 parity", 0, 0, 0, 0, 0);
    // R6 length faults and trailer value
    build(16'h2228, 8'h33, 16'h0044, 0, 0); to_pulses(0); np = np - 2;
    run("R6 short count", 0, 0, 0, 0, 0);
    build(16'h2229, 8'h33, 16'h0044, 0, 0); to_pulses(0);
    pd[np] = 16; pd[np+1] = 16; np = np + 2;
    run("R6 long count", 0, 0, 0, 0, 0);
    build(16'h3131, 8'h07, 16'h0055, 0, 0); fb[nb-1] = 1'b1; to_pulses(0);
    run("R6 trailer ignored", 1, 16'h3131, 8'h07, 16'h0055, 0);
    // R8 recovery after a drop
    build(16'h2230, 8'h33, 16'h0044, 0, 0); to_pulses(0); pd[7] = 40;
    run("R8 drop", 0, 0, 0, 0, 0);
    build(16'h4545, 8'h99, 16'h00AA, 0, 0); to_pulses(1);
    run("R8 recovery", 1, 16'h4545, 8'h99, 16'h00AA, 0);

    for (int i = 0; i < 10; i++) begin
      h = 16'($urandom); a = 8'($urandom); c = 16'($urandom);
      w = bit'($urandom % 2); co = int'($urandom % 5);
      build(h, a, c, w, co); to_pulses(1);
      run("R5 random", co <= 2, h, a, c, w);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule